// File: doc/BRIEF.md
# Status Register and Write-Permission Unit

This block holds the 8-bit status word of a small serial memory and makes every write-permission decision for it. The command controller brings it requests: raise or drop the write latch, write the status word, or ask whether one array location may be written. The block also watches the write-protect pin (active low) and the busy flag of the internal write engine. It returns the status read value, a grant for the status write, a grant for the array write, the lower bound of the protected address range, and a flag that shows when the hardware lock is active.

Three protection layers are combined. A software latch must be set before any change and drops after each change attempt. A two-bit range selector blocks the top quarter, the top half or all of the array. A hardware lock makes the status word read-only when the pin is low and the lock-enable bit is set. The stored bits are plain registers whose reset values stand in for the values a non-volatile part holds at power-up. Serial shifting and array storage are handled elsewhere.

Top module: `prot_status_unit`

## Requirements
- R1: Reset leaves the status read at 0x00, the write latch, the lock-enable bit and both range bits at 0, both grants low, and `prot_lo_o` equal to the array depth (1024), so no address is protected.
- R2: When not busy, the status read places lock-enable at bit 7, the range selector at bits 3:2 (bit 3 high), the write latch at bit 1, and reads 0 at bits 6:4 and bit 0.
- R3: While `busy_i` is 1, the status read is 0xFF, both grants are 0, and latch-set requests and status-write requests leave the stored state unchanged.
- R4: The write latch is set one cycle after a latch-set request made while not busy. It is cleared by a latch-clear request, by an array write-done pulse, and by any status-write request made while not busy, whether or not the write was granted. A clear wins over a set in the same cycle.
- R5: A status write is granted in the same cycle when the latch is 1, the hardware lock is inactive and the unit is not busy. On a grant, lock-enable takes data bit 7 and the range selector takes data bits 3:2. Data bits 6:4, 1 and 0 are discarded.
- R6: `hw_lock_o` is 1 exactly when `wp_n_i` is 0 and lock-enable is 1. The hardware lock never affects array grants.
- R7: While `wp_n_i` is 0, a lock-enable of 1 cannot be cleared. A lock-enable of 0 can still be set to 1 while `wp_n_i` is 0.
- R8: The range selector maps to `prot_lo_o` as follows: 00 gives 1024 (nothing protected), 01 gives 768 (0x300 to 0x3FF), 10 gives 512 (0x200 to 0x3FF), 11 gives 0 (the whole array). An address is protected when it is at or above `prot_lo_o`, whatever the state of the latch, lock-enable or pin.
- R9: `arr_grant_o` is 1 in the same cycle as `arr_req_i` exactly when the latch is 1, the unit is not busy and `arr_addr_i` is below `prot_lo_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; loads the power-up values |
| wp_n_i | input | 1 | Write-protect pin, active low |
| busy_i | input | 1 | Internal write cycle in progress |
| wel_set_i | input | 1 | Request to set the write latch |
| wel_clr_i | input | 1 | Request to clear the write latch |
| sr_wr_i | input | 1 | Request to write the status word |
| sr_wdata_i | input | 8 | Status write data |
| arr_req_i | input | 1 | Request for permission to write one array location |
| arr_addr_i | input | ADDR_W | Array address of the request |
| arr_done_i | input | 1 | Pulse when an array write completes |
| sr_rdata_o | output | 8 | Status read value |
| sr_grant_o | output | 1 | Status write granted |
| arr_grant_o | output | 1 | Array write granted |
| prot_lo_o | output | ADDR_W+1 | First protected address; equals the array depth when nothing is protected |
| hw_lock_o | output | 1 | Hardware lock active |

## Verification
The bench sweeps every array address under each of the four range settings and compares each grant with a threshold it computes itself. A decoder that shifted a range by one address, or that swapped the quarter and half settings, fails on the boundary addresses 0x1FF, 0x200, 0x2FF and 0x300. It also tests the asymmetric lock-enable rule from both sides: a design that let lock-enable clear with the pin low, or that refused to set it with the pin low, reads back the wrong bit 7. Busy-time requests are checked through the read value after busy drops, so a design that latched a set or a status write while busy shows a wrong latch or range bit. A refused status write must still drop the latch.

// File: rtl/prot_status_pkg.sv
package prot_status_pkg;

  // Bit positions that the status decoder outside this block relies on
  localparam int SR_LOCK_EN = 7;
  localparam int SR_RNG_HI  = 3;
  localparam int SR_RNG_LO  = 2;
  localparam int SR_LATCH   = 1;
  localparam int SR_BUSY    = 0;

  typedef enum logic [1:0] {
    RNG_NONE    = 2'b00,
    RNG_QUARTER = 2'b01,
    RNG_HALF    = 2'b10,
    RNG_ALL     = 2'b11
  } rng_sel_e;

  // First protected address for a range setting; depth means nothing protected
  function automatic logic [31:0] prot_floor(input logic [1:0] sel, input int unsigned depth);
    case (rng_sel_e'(sel))
      RNG_NONE:    return 32'(depth);
      RNG_QUARTER: return 32'(depth - depth / 4);
      RNG_HALF:    return 32'(depth / 2);
      default:     return 32'd0;
    endcase
  endfunction

  // Status word image when no write is in flight
  function automatic logic [7:0] pack_status(input logic lock_en, input logic [1:0] rng,
                                             input logic latch);
    logic [7:0] w;
    w = 8'h00;
    w[SR_LOCK_EN]          = lock_en;
    w[SR_RNG_HI:SR_RNG_LO] = rng;
    w[SR_LATCH]            = latch;
    w[SR_BUSY]             = 1'b0;
    return w;
  endfunction

endpackage

// File: rtl/prot_wel.sv
module prot_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic set_req,
  input  logic clr_req,
  input  logic sr_wr_req,
  input  logic done_pulse,
  output logic latch
);

  logic set_evt;
  logic clr_evt;

  assign set_evt = set_req & ~busy;
  assign clr_evt = clr_req | done_pulse | (sr_wr_req & ~busy);

  always_ff @(posedge clk) begin
    if (!rst_n)       latch <= 1'b0;
    else if (clr_evt) latch <= 1'b0;
    else if (set_evt) latch <= 1'b1;
  end

  // R4
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> !latch);

  // R4
  wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && !clr_evt) |=> latch);

  // R3
  wel_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !latch) |=> !latch);

endmodule

// File: rtl/prot_cfg_regs.sv
module prot_cfg_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_req,
  input  logic       latch,
  input  logic       busy,
  input  logic       wp_n,
  input  logic       lock_en_d,
  input  logic [1:0] rng_d,
  output logic       lock_en,
  output logic [1:0] rng,
  output logic       hw_lock,
  output logic       wr_grant
);

  assign hw_lock  = lock_en & ~wp_n;
  assign wr_grant = wr_req & latch & ~hw_lock & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_en <= 1'b0;
      rng     <= 2'b00;
    end else if (wr_grant) begin
      lock_en <= lock_en_d;
      rng     <= rng_d;
    end
  end

  // R7
  lock_en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_en && !wp_n) |=> lock_en);

  // R5
  rng_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_grant |=> (rng == $past(rng_d)) && (lock_en == $past(lock_en_d)));

  // R5
  cfg_refuse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_grant) |=> $stable(rng) && $stable(lock_en));

endmodule

// File: rtl/prot_range_decode.sv
module prot_range_decode #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        rng,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W:0]   lo,
  output logic              hit
);
  import prot_status_pkg::*;

  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int          LO_W  = ADDR_W + 1;

  assign lo  = LO_W'(prot_floor(rng, DEPTH));
  assign hit = ({1'b0, addr} >= lo);

  // R8
  rng_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rng == 2'b11) |-> hit);

  // R8
  rng_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rng == 2'b00) |-> !hit);

endmodule

// File: rtl/prot_status_unit.sv
module prot_status_unit #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n_i,
  input  logic              busy_i,
  input  logic              wel_set_i,
  input  logic              wel_clr_i,
  input  logic              sr_wr_i,
  input  logic [7:0]        sr_wdata_i,
  input  logic              arr_req_i,
  input  logic [ADDR_W-1:0] arr_addr_i,
  input  logic              arr_done_i,
  output logic [7:0]        sr_rdata_o,
  output logic              sr_grant_o,
  output logic              arr_grant_o,
  output logic [ADDR_W:0]   prot_lo_o,
  output logic              hw_lock_o
);
  import prot_status_pkg::*;

  logic       latch;
  logic       lock_en;
  logic [1:0] rng;
  logic       in_range;
  logic       unused_wbits;

  assign unused_wbits = ^{sr_wdata_i[6:4], sr_wdata_i[SR_LATCH], sr_wdata_i[SR_BUSY]};

  prot_wel u_wel (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy_i),
    .set_req    (wel_set_i),
    .clr_req    (wel_clr_i),
    .sr_wr_req  (sr_wr_i),
    .done_pulse (arr_done_i),
    .latch      (latch)
  );

  prot_cfg_regs u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_req    (sr_wr_i),
    .latch     (latch),
    .busy      (busy_i),
    .wp_n      (wp_n_i),
    .lock_en_d (sr_wdata_i[SR_LOCK_EN]),
    .rng_d     (sr_wdata_i[SR_RNG_HI:SR_RNG_LO]),
    .lock_en   (lock_en),
    .rng       (rng),
    .hw_lock   (hw_lock_o),
    .wr_grant  (sr_grant_o)
  );

  prot_range_decode #(.ADDR_W(ADDR_W)) u_rng (
    .clk   (clk),
    .rst_n (rst_n),
    .rng   (rng),
    .addr  (arr_addr_i),
    .lo    (prot_lo_o),
    .hit   (in_range)
  );

  assign sr_rdata_o  = busy_i ? 8'hFF : pack_status(lock_en, rng, latch);
  assign arr_grant_o = arr_req_i & latch & ~busy_i & ~in_range;

  // R9
  arr_grant_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_grant_o |-> ({1'b0, arr_addr_i} < prot_lo_o) && sr_rdata_o[SR_LATCH]);

  // R3
  busy_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> (sr_rdata_o == 8'hFF) && !arr_grant_o && !sr_grant_o);

  // R2
  idle_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |-> (sr_rdata_o[6:4] == 3'b000) && !sr_rdata_o[SR_BUSY]);

  // R5
  sr_grant_drops_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_grant_o |=> !sr_rdata_o[SR_LATCH] || busy_i);

endmodule

// File: tb/prot_status_unit_test.sv
module prot_status_unit_test;

  localparam int CLK_P  = 10;
  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wp_n_i, busy_i, wel_set_i, wel_clr_i, sr_wr_i, arr_req_i, arr_done_i;
  logic [7:0]        sr_wdata_i;
  logic [ADDR_W-1:0] arr_addr_i;
  logic [7:0]        sr_rdata_o;
  logic              sr_grant_o, arr_grant_o, hw_lock_o;
  logic [ADDR_W:0]   prot_lo_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // bench model of the stored state, kept from the requirements
  bit       m_latch, m_lock;
  bit [1:0] m_rng;

  always #(CLK_P/2) clk = ~clk;

  prot_status_unit #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .wp_n_i(wp_n_i), .busy_i(busy_i),
    .wel_set_i(wel_set_i), .wel_clr_i(wel_clr_i), .sr_wr_i(sr_wr_i),
    .sr_wdata_i(sr_wdata_i), .arr_req_i(arr_req_i), .arr_addr_i(arr_addr_i),
    .arr_done_i(arr_done_i), .sr_rdata_o(sr_rdata_o), .sr_grant_o(sr_grant_o),
    .arr_grant_o(arr_grant_o), .prot_lo_o(prot_lo_o), .hw_lock_o(hw_lock_o)
  );

  function automatic int exp_lo(input bit [1:0] r);
    int q;
    q = DEPTH / 4;
    if (r == 2'd0) return DEPTH;
    if (r == 2'd1) return DEPTH - q;
    if (r == 2'd2) return 2 * q;
    return 0;
  endfunction

  function automatic int exp_sr();
    if (busy_i) return 255;
    return (int'(m_lock) * 128) + (int'(m_rng) * 4) + (int'(m_latch) * 2);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_set();
    wel_set_i = 1'b1;
    step();
    wel_set_i = 1'b0;
    if (!busy_i) m_latch = 1'b1;
  endtask

  task automatic do_sr_write(input logic [7:0] d, input string tag);
    bit g;
    sr_wr_i = 1'b1;
    sr_wdata_i = d;
    g = m_latch && !(m_lock && !wp_n_i) && !busy_i;
    #1;
    chk({tag, " grant"}, int'(sr_grant_o), int'(g));
    step();
    sr_wr_i = 1'b0;
    if (g) begin
      m_lock = d[7];
      m_rng  = d[3:2];
    end
    if (!busy_i) m_latch = 1'b0;
    #1;
    chk({tag, " read"}, int'(sr_rdata_o), exp_sr());
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wp_n_i = 1'b1; busy_i = 1'b0; wel_set_i = 1'b0; wel_clr_i = 1'b0;
    sr_wr_i = 1'b0; sr_wdata_i = 8'h00; arr_req_i = 1'b0; arr_addr_i = '0; arr_done_i = 1'b0;
    m_latch = 1'b0; m_lock = 1'b0; m_rng = 2'b00;
    repeat (3) step();
    rst_n = 1'b1;
    #1;

    // R1 reset state
    arr_req_i = 1'b1;
    #1;
    chk("R1 read", int'(sr_rdata_o), 0);
    chk("R1 lo", int'(prot_lo_o), DEPTH);
    chk("R1 arr grant", int'(arr_grant_o), 0);
    chk("R1 hw lock", int'(hw_lock_o), 0);
    sr_wr_i = 1'b1;
    #1;
    chk("R1 sr grant", int'(sr_grant_o), 0);
    sr_wr_i = 1'b0;
    arr_req_i = 1'b0;

    // R4 latch set and the clear sources, R2 latch bit position
    do_set();
    chk("R4 set / R2 bit1", int'(sr_rdata_o), 2);
    arr_req_i = 1'b1; arr_addr_i = 10'd5;
    #1;
    chk("R9 grant with latch", int'(arr_grant_o), 1);
    arr_req_i = 1'b0;
    wel_clr_i = 1'b1; step(); wel_clr_i = 1'b0; m_latch = 1'b0;
    chk("R4 clear request", int'(sr_rdata_o), exp_sr());
    wel_set_i = 1'b1; wel_clr_i = 1'b1; step(); wel_set_i = 1'b0; wel_clr_i = 1'b0;
    chk("R4 clear wins", int'(sr_rdata_o), exp_sr());
    do_set();
    arr_done_i = 1'b1; step(); arr_done_i = 1'b0; m_latch = 1'b0;
    chk("R4 done pulse", int'(sr_rdata_o), exp_sr());

    // R5 R8 R9: each range, with dropped bits set in the data; full address sweep
    for (int r = 0; r < 4; r++) begin
      do_set();
      do_sr_write({1'b0, 3'b111, 2'(r), 2'b11}, "R5 R2 range write");
      chk("R4 latch after write", int'(sr_rdata_o[1]), 0);
      chk("R8 lo", int'(prot_lo_o), exp_lo(2'(r)));
      do_set();
      arr_req_i = 1'b1;
      for (int a = 0; a < DEPTH; a++) begin
        arr_addr_i = ADDR_W'(a);
        #1;
        chk("R9 R8 addr sweep", int'(arr_grant_o), (a < exp_lo(2'(r))) ? 1 : 0);
      end
      busy_i = 1'b1;
      arr_addr_i = '0;
      #1;
      chk("R3 busy arr grant", int'(arr_grant_o), 0);
      chk("R3 busy read", int'(sr_rdata_o), 255);
      busy_i = 1'b0;
      arr_req_i = 1'b0;
      wel_clr_i = 1'b1; step(); wel_clr_i = 1'b0; m_latch = 1'b0;
    end

    // R3: requests while busy leave state untouched
    busy_i = 1'b1;
    do_set();
    busy_i = 1'b0;
    #1;
    chk("R3 set ignored", int'(sr_rdata_o), exp_sr());
    do_set();
    busy_i = 1'b1;
    do_sr_write(8'h84, "R3 write while busy");
    busy_i = 1'b0;
    #1;
    chk("R3 state kept", int'(sr_rdata_o), exp_sr());

    // R6 R7: hardware lock
    do_sr_write(8'h80, "R7 set lock-enable pin high");
    chk("R7 lock bit", int'(sr_rdata_o[7]), 1);
    #1;
    chk("R6 lock off pin high", int'(hw_lock_o), 0);
    wp_n_i = 1'b0;
    #1;
    chk("R6 lock on pin low", int'(hw_lock_o), 1);
    do_set();
    do_sr_write(8'h00, "R7 clear refused");
    chk("R7 lock bit kept", int'(sr_rdata_o[7]), 1);
    chk("R4 refused write drops latch", int'(sr_rdata_o[1]), 0);
    do_set();
    arr_req_i = 1'b1; arr_addr_i = 10'h100;
    #1;
    chk("R6 array not locked", int'(arr_grant_o), 1);
    arr_req_i = 1'b0;
    wp_n_i = 1'b1;
    do_sr_write(8'h00, "R7 clear pin high");
    chk("R7 lock cleared", int'(sr_rdata_o[7]), 0);
    wp_n_i = 1'b0;
    #1;
    chk("R6 no lock when bit 0", int'(hw_lock_o), 0);
    do_set();
    do_sr_write(8'h84, "R7 set lock-enable pin low");
    chk("R7 set allowed", int'(sr_rdata_o), 132);
    chk("R6 lock after set", int'(hw_lock_o), 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule